// File: doc/BRIEF.md
# Processor-side interrupt acknowledge port

This block sits between an interrupt distributor and one processor. Each cycle the distributor presents its best pending candidate, an ID and an 8-bit priority. Lower numbers mean more urgent. The port decides whether that candidate may interrupt the processor. It passes only if the port is enabled, the candidate beats a programmable priority threshold, and the candidate beats the priority of the handler now running. If it passes, the port raises a registered request line.

Software takes an interrupt by reading the acknowledge register. That read returns the candidate's ID and pushes the ID and priority onto a small stack of active handlers. When nothing qualifies, the read returns the reserved ID 1023 and changes nothing. Software retires a handler by writing its ID to the end-of-interrupt register. Only the innermost active handler can be retired this way. One cycle after each acknowledge or retirement, the port sends a strobe with the ID back to the distributor.

A handler of more urgent priority may preempt a running one, up to a parameterised nesting depth. A grouping shift sets how many low priority bits are ignored when deciding preemption.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the request line is low, the control, threshold and grouping registers read 0, and the running-priority register reads 0xFF.
- R2: While control bit 0 (offset 0x000) is 0, the request line stays low and an acknowledge read returns 1023.
- R3: The candidate can be signalled only when its priority is numerically below the threshold register (offset 0x004, bits 7:0). A threshold of 0xFF admits every priority below 0xFF, and a threshold of 0 admits none.
- R4: A read of offset 0x00C while the candidate qualifies returns its ID in bits 9:0 and makes its priority the running priority. One cycle later, `ack_o` pulses with `ack_id_o` equal to that ID.
- R5: A read of offset 0x00C while no candidate qualifies returns 1023, produces no acknowledge strobe, and leaves the running priority unchanged.
- R6: While a handler is active, the candidate qualifies only if (candidate priority >> G) is strictly less than (running priority >> G). G is the grouping register (offset 0x008, bits 2:0), and G = 0 compares all 8 bits.
- R7: Writing the ID of the innermost active handler to offset 0x010 removes that handler. The running priority returns to that of the next outer handler, or to 0xFF when none remains. One cycle later, `eoi_o` pulses with that ID.
- R8: An end-of-interrupt write whose ID differs from the innermost active handler, or that arrives with nothing active, changes no state and gives no strobe.
- R9: When NEST handlers (default 4) are active, the request line stays low and acknowledge reads return 1023.
- R10: The running priority reads at offset 0x014. The request line reflects the inputs and state of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| cand_valid | input | 1 | Distributor has a pending candidate |
| cand_id | input | 10 | Candidate ID |
| cand_prio | input | 8 | Candidate priority, 0 most urgent |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_o | output | 1 | Acknowledge strobe to the distributor |
| ack_id_o | output | 10 | ID that was acknowledged |
| eoi_o | output | 1 | Retirement strobe to the distributor |
| eoi_id_o | output | 10 | ID that was retired |

## Verification
The assertions take for granted that the distributor never offers 1023 as a real candidate ID, so a returned 1023 always means a spurious read. They also assume that at most one register access happens per cycle. The stimulus keeps to both: candidate IDs stay well below 1023, and the bus tasks drive a single access and drop `bus_sel` before the next one. Candidates change only at falling edges, so the registered request line can be compared against the previous cycle's values.

// File: rtl/cif_pkg.sv
package cif_pkg;
    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_MASK = 3'd1,
        REG_GRP  = 3'd2,
        REG_ACK  = 3'd3,
        REG_EOI  = 3'd4,
        REG_RUN  = 3'd5
    } reg_idx_e;
endpackage

// File: rtl/cif_regs.sv
module cif_regs #(
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned GRP_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_mask,
    input  logic              wr_grp,
    input  logic [PRIO_W-1:0] wdata,
    output logic              en,
    output logic [PRIO_W-1:0] mask,
    output logic [GRP_W-1:0]  grp
);
    typedef struct packed {
        logic              en;
        logic [PRIO_W-1:0] mask;
        logic [GRP_W-1:0]  grp;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) r_d.en   = wdata[0];
        if (wr_mask) r_d.mask = wdata;
        if (wr_grp)  r_d.grp  = wdata[GRP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en   = r_q.en;
    assign mask = r_q.mask;
    assign grp  = r_q.grp;
endmodule

// File: rtl/cif_prio_gate.sv
module cif_prio_gate #(
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned GRP_W  = 3
) (
    input  logic              en,
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] mask,
    input  logic [GRP_W-1:0]  grp,
    input  logic              stk_empty,
    input  logic              stk_full,
    input  logic [PRIO_W-1:0] run_prio,
    output logic              qualify
);
    logic below_mask;
    logic beats_run;

    always_comb begin
        below_mask = cand_prio < mask;
        beats_run  = stk_empty || ((cand_prio >> grp) < (run_prio >> grp));
        qualify    = en && cand_valid && below_mask && beats_run && !stk_full;
    end
endmodule

// File: rtl/cif_active_stack.sv
module cif_active_stack #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ID_W   = 10,
    parameter int unsigned PRIO_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [ID_W-1:0]              push_id,
    input  logic [PRIO_W-1:0]            push_prio,
    input  logic                         pop,
    output logic [ID_W-1:0]              top_id,
    output logic [PRIO_W-1:0]            top_prio,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]   cnt;
    } stk_t;

    stk_t   s_d, s_q;
    entry_t top;

    always_comb begin
        s_d = s_q;
        if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (s_q.cnt == CNT_W'(i)) s_d.ent[i] = '{id: push_id, prio: push_prio};
            end
            s_d.cnt = s_q.cnt + 1'b1;
        end else if (pop && !empty) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (s_q.cnt == CNT_W'(i + 1)) top = s_q.ent[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign empty    = (s_q.cnt == '0);
    assign full     = (s_q.cnt == CNT_W'(DEPTH));
    assign top_id   = top.id;
    assign top_prio = top.prio;
    assign count    = s_q.cnt;
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface #(
    parameter int unsigned ID_W   = 10,
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned NEST   = 4,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    output logic              irq_o,
    output logic              ack_o,
    output logic [ID_W-1:0]   ack_id_o,
    output logic              eoi_o,
    output logic [ID_W-1:0]   eoi_id_o
);
    import cif_pkg::*;

    localparam int unsigned GRP_W = $clog2(PRIO_W);
    localparam int unsigned CNT_W = $clog2(NEST + 1);
    localparam logic [ID_W-1:0] SPUR_ID = '1;
    localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

    typedef struct packed {
        logic            irq;
        logic            ack;
        logic [ID_W-1:0] ack_id;
        logic            eoi;
        logic [ID_W-1:0] eoi_id;
    } out_t;

    out_t o_d, o_q;

    reg_idx_e          idx;
    logic              rd_ack, wr_eoi;
    logic              ctrl_en;
    logic [PRIO_W-1:0] mask_val;
    logic [GRP_W-1:0]  grp_val;
    logic              stk_empty, stk_full;
    logic [ID_W-1:0]   top_id;
    logic [PRIO_W-1:0] top_prio;
    logic [CNT_W-1:0]  stk_cnt;
    logic [PRIO_W-1:0] run_prio;
    logic              qualify;
    logic              do_push, do_pop;
    logic              unused_bits;

    assign idx    = reg_idx_e'(bus_addr[4:2]);
    assign rd_ack = bus_sel && !bus_wr && (idx == REG_ACK);
    assign wr_eoi = bus_sel && bus_wr && (idx == REG_EOI);
    assign unused_bits = ^{bus_wdata[DATA_W-1:ID_W], bus_addr[1:0]};

    cif_regs #(.PRIO_W(PRIO_W), .GRP_W(GRP_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (bus_sel && bus_wr && (idx == REG_CTRL)),
        .wr_mask (bus_sel && bus_wr && (idx == REG_MASK)),
        .wr_grp  (bus_sel && bus_wr && (idx == REG_GRP)),
        .wdata   (bus_wdata[PRIO_W-1:0]),
        .en      (ctrl_en),
        .mask    (mask_val),
        .grp     (grp_val)
    );

    assign run_prio = stk_empty ? IDLE_PRIO : top_prio;

    cif_prio_gate #(.PRIO_W(PRIO_W), .GRP_W(GRP_W)) u_gate (
        .en         (ctrl_en),
        .cand_valid (cand_valid),
        .cand_prio  (cand_prio),
        .mask       (mask_val),
        .grp        (grp_val),
        .stk_empty  (stk_empty),
        .stk_full   (stk_full),
        .run_prio   (run_prio),
        .qualify    (qualify)
    );

    assign do_push = rd_ack && qualify;
    assign do_pop  = wr_eoi && !stk_empty && (bus_wdata[ID_W-1:0] == top_id);

    cif_active_stack #(.DEPTH(NEST), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .push_id   (cand_id),
        .push_prio (cand_prio),
        .pop       (do_pop),
        .top_id    (top_id),
        .top_prio  (top_prio),
        .empty     (stk_empty),
        .full      (stk_full),
        .count     (stk_cnt)
    );

    always_comb begin
        bus_rdata = '0;
        case (idx)
            REG_CTRL: bus_rdata[0]          = ctrl_en;
            REG_MASK: bus_rdata[PRIO_W-1:0] = mask_val;
            REG_GRP:  bus_rdata[GRP_W-1:0]  = grp_val;
            REG_ACK:  bus_rdata[ID_W-1:0]   = qualify ? cand_id : SPUR_ID;
            REG_RUN:  bus_rdata[PRIO_W-1:0] = run_prio;
            default:  bus_rdata             = '0;
        endcase
    end

    always_comb begin
        o_d        = o_q;
        o_d.irq    = qualify;
        o_d.ack    = do_push;
        o_d.eoi    = do_pop;
        if (do_push) o_d.ack_id = cand_id;
        if (do_pop)  o_d.eoi_id = top_id;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq_o    = o_q.irq;
    assign ack_o    = o_q.ack;
    assign ack_id_o = o_q.ack_id;
    assign eoi_o    = o_q.eoi;
    assign eoi_id_o = o_q.eoi_id;
endmodule

// File: rtl/cif_checker.sv
module cif_checker #(
    parameter int unsigned ID_W   = 10,
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned NEST   = 4,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [PRIO_W-1:0]          cand_prio,
    input logic                       irq_o,
    input logic                       ack_o,
    input logic [ID_W-1:0]            ack_id_o,
    input logic                       eoi_o,
    input logic [ID_W-1:0]            eoi_id_o,
    input logic                       ctrl_en,
    input logic [PRIO_W-1:0]          mask_val,
    input logic [PRIO_W-1:0]          run_prio,
    input logic [$clog2(NEST+1)-1:0]  stk_cnt
);
    localparam logic [DATA_W-1:0] SPUR = DATA_W'((1 << ID_W) - 1);

    logic ack_read;
    assign ack_read = bus_sel && !bus_wr && (bus_addr[4:2] == 3'd3);

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !irq_o);

    p_mask_strict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(cand_prio) < $past(mask_val)));

    p_beats_running_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(cand_prio) < $past(run_prio)));

    p_ack_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (ack_id_o == $past(bus_rdata[ID_W-1:0])));

    p_spurious_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_read && bus_rdata == SPUR) |=> (!ack_o && stk_cnt == $past(stk_cnt)));

    p_eoi_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_o |-> (eoi_id_o == $past(bus_wdata[ID_W-1:0]) && stk_cnt == $past(stk_cnt) - 1'b1));

    p_full_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_cnt == ($clog2(NEST+1))'(NEST)) |=> !irq_o);

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_o && eoi_o));

    always_comb begin
        if (rst_n) p_depth_bound_r9: assert (stk_cnt <= ($clog2(NEST+1))'(NEST));
    end
endmodule

bind cpu_irq_iface cif_checker #(
    .ID_W(ID_W), .PRIO_W(PRIO_W), .NEST(NEST), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cand_prio(cand_prio), .irq_o(irq_o), .ack_o(ack_o), .ack_id_o(ack_id_o),
    .eoi_o(eoi_o), .eoi_id_o(eoi_id_o), .ctrl_en(ctrl_en), .mask_val(mask_val),
    .run_prio(run_prio), .stk_cnt(stk_cnt)
);

// File: tb/cpu_irq_iface_tb.sv
module cpu_irq_iface_tb;
    localparam logic [4:0] A_CTRL = 5'h00, A_MASK = 5'h04, A_GRP = 5'h08,
                           A_ACK  = 5'h0C, A_EOI  = 5'h10, A_RUN = 5'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cand_valid = 1'b0;
    logic [9:0]  cand_id = '0;
    logic [7:0]  cand_prio = '0;
    logic        irq_o, ack_o, eoi_o;
    logic [9:0]  ack_id_o, eoi_id_o;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic        last_ack, last_eoi;
    logic [9:0]  last_ack_id, last_eoi_id;
    logic [31:0] rv;

    always #5 clk = ~clk;

    cpu_irq_iface u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
        .irq_o(irq_o), .ack_o(ack_o), .ack_id_o(ack_id_o),
        .eoi_o(eoi_o), .eoi_id_o(eoi_id_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        last_eoi = eoi_o; last_eoi_id = eoi_id_o;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
        last_ack = ack_o; last_ack_id = ack_id_o;
    endtask

    task automatic cand(input logic v, input logic [9:0] id, input logic [7:0] p);
        @(negedge clk);
        cand_valid = v; cand_id = id; cand_prio = p;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 irq", irq_o, 0);
        rd(A_CTRL, rv); chk("R1 ctrl", rv, 0);
        rd(A_MASK, rv); chk("R1 mask", rv, 0);
        rd(A_GRP, rv);  chk("R1 grp", rv, 0);
        rd(A_RUN, rv);  chk("R1 run", rv, 'hFF);

        // R2 disabled port
        wr(A_MASK, 'hFF);
        cand(1, 10'd5, 8'h10);
        chk("R2 irq while disabled", irq_o, 0);
        rd(A_ACK, rv); chk("R2 ack disabled", rv, 1023);
        chk("R2 no strobe", last_ack, 0);

        // R10 register readback
        wr(A_CTRL, 1); rd(A_CTRL, rv); chk("R10 ctrl", rv, 1);
        wr(A_GRP, 5);  rd(A_GRP, rv);  chk("R10 grp", rv, 5);
        wr(A_GRP, 0);
        wr(A_MASK, 'hA5); rd(A_MASK, rv); chk("R10 mask", rv, 'hA5);

        // R3 exhaustive threshold sweep
        foreach (rv[i]) begin end
        for (int m = 0; m < 5; m++) begin
            int mv;
            mv = (m == 0) ? 0 : (m == 1) ? 1 : (m == 2) ? 'h40 : (m == 3) ? 'hA0 : 'hFF;
            wr(A_MASK, mv);
            for (int p = 0; p < 256; p++) begin
                cand(1, 10'd7, p[7:0]);
                chk("R3 threshold", irq_o, (p < mv) ? 1 : 0);
            end
        end
        cand(0, 10'd7, 8'h00);
        chk("R3 no valid", irq_o, 0);

        // R4 acknowledge
        cand(1, 10'd153, 8'hA0);
        chk("R10 irq latency", irq_o, 1);
        rd(A_ACK, rv); chk("R4 ack id", rv, 153);
        chk("R4 strobe", last_ack, 1);
        chk("R4 strobe id", last_ack_id, 153);
        rd(A_RUN, rv); chk("R4 running", rv, 'hA0);
        chk("R6 same prio blocked", irq_o, 0);

        // R6 preemption sweep over grouping shift
        for (int g = 0; g < 8; g++) begin
            wr(A_GRP, g);
            for (int p = 0; p < 256; p++) begin
                cand(1, 10'd20, p[7:0]);
                chk("R6 preempt", irq_o, (((p >> g) < ('hA0 >> g)) && p < 'hFF) ? 1 : 0);
            end
        end
        wr(A_GRP, 0);

        // R8 mismatched retirement
        wr(A_EOI, 100); chk("R8 no strobe", last_eoi, 0);
        rd(A_RUN, rv);  chk("R8 running kept", rv, 'hA0);
        // R7 retirement
        wr(A_EOI, 153); chk("R7 strobe", last_eoi, 1);
        chk("R7 strobe id", last_eoi_id, 153);
        rd(A_RUN, rv);  chk("R7 idle", rv, 'hFF);
        wr(A_EOI, 153); chk("R8 empty ignored", last_eoi, 0);

        // R5 spurious
        wr(A_MASK, 'h10);
        cand(1, 10'd30, 8'h20);
        rd(A_ACK, rv); chk("R5 spurious", rv, 1023);
        chk("R5 no strobe", last_ack, 0);
        rd(A_RUN, rv); chk("R5 running", rv, 'hFF);

        // R9 nesting to full
        wr(A_MASK, 'hFF);
        for (int k = 0; k < 4; k++) begin
            cand(1, 10'(10 + k), 8'(8'h80 - 8'(k * 'h20)));
            rd(A_ACK, rv); chk("R9 nested ack", rv, 10 + k);
        end
        cand(1, 10'd14, 8'h00);
        chk("R9 full irq", irq_o, 0);
        rd(A_ACK, rv); chk("R9 full spurious", rv, 1023);
        rd(A_RUN, rv); chk("R9 running", rv, 'h20);
        cand(0, 10'd0, 8'h00);
        wr(A_EOI, 12); chk("R8 not innermost", last_eoi, 0);
        for (int k = 3; k >= 0; k--) begin
            wr(A_EOI, 10 + k);
            chk("R7 unwind strobe", last_eoi, 1);
            rd(A_RUN, rv);
            chk("R7 unwind running", rv, (k == 0) ? 'hFF : ('h80 - (k - 1) * 'h20));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule